// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for every received frame, whether the frame is taken in and of which address class it is. Destination address bytes stream in one per cycle, qualified by a valid strobe, with a start marker on the first byte. An end strobe then brings the frame length (counted without the frame check sequence). One cycle after that strobe the filter pulses a done flag and presents an accept/reject verdict with two class flags: group (multicast) and broadcast.

The verdict comes from a fixed chain of rules, applied in priority order. Short frames are settled first, by the runt-accept control alone. Promiscuous mode then takes every individual (non-group) address. All-multicast mode takes every group address. Broadcast-accept takes the all-ones address. Last, a table of sixteen station addresses is searched in parallel, and only entries whose enable bit is set count. Table entries are written one 16-bit word at a time, three words to an entry, and the enable mask is written as a whole word.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `flt_done`, `flt_accept`, `flt_mcast` and `flt_bcast` are all 0, and every table entry is disabled.
- R2: `flt_done` is high for exactly the one cycle that follows a cycle with `rx_eof` high, and at no other time.
- R3: A frame with `rx_len` below 60 is accepted if and only if `cfg_runt_ok` is 1, with both class flags 0, whatever its address and the other controls.
- R4: For a frame of 60 bytes or more with `cfg_promisc` set, a destination whose first byte has bit 0 clear is accepted with both class flags 0.
- R5: Otherwise, with `cfg_all_mcast` set, a destination whose first byte has bit 0 set is accepted with `flt_mcast` 1 and `flt_bcast` 0. This holds for the all-ones address too.
- R6: Otherwise, with `cfg_bcast_ok` set, a destination of six 0xFF bytes is accepted with `flt_bcast` 1 and `flt_mcast` 0. The two class flags are never both 1, and neither is 1 on a rejected frame.
- R7: Otherwise, a destination that equals all 48 bits of a table entry whose bit in the enable mask is 1 is accepted with no class flag. Entries whose enable bit is 0 never match.
- R8: A table write with `tbl_wr_word` = w (0..2) stores `tbl_wr_data` into entry `tbl_wr_idx`: the low byte becomes destination byte 2w and the high byte byte 2w+1, where byte 0 is the first byte received. `tbl_wr_word` = 3 changes nothing.
- R9: A frame of 60 bytes or more that meets none of the rules above is rejected, with both class flags 0.
- R10: `flt_accept`, `flt_mcast` and `flt_bcast` keep their values in every cycle in which `flt_done` is 0.
- R11: The destination is made of the byte given with `rx_sof` and the next five valid bytes. Later bytes of the frame are ignored, and a new `rx_sof` restarts capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_runt_ok | input | 1 | Accept frames shorter than 60 bytes |
| cfg_promisc | input | 1 | Accept every individual address |
| cfg_all_mcast | input | 1 | Accept every group address, flagged multicast |
| cfg_bcast_ok | input | 1 | Accept the all-ones address, flagged broadcast |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_idx | input | 4 | Table entry written |
| tbl_wr_word | input | 2 | Word within the entry (0..2; 3 is ignored) |
| tbl_wr_data | input | 16 | Word data, low byte is the earlier address byte |
| tbl_mask_we | input | 1 | Enable mask write strobe |
| tbl_mask_data | input | 16 | Enable mask, bit e enables entry e |
| rx_sof | input | 1 | First destination byte marker |
| rx_byte_vld | input | 1 | `rx_byte` is valid |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End of frame, `rx_len` valid |
| rx_len | input | 16 | Frame length in bytes without check sequence |
| flt_done | output | 1 | Verdict pulse |
| flt_accept | output | 1 | Frame accepted |
| flt_mcast | output | 1 | Accepted as group address |
| flt_bcast | output | 1 | Accepted as broadcast |

## Verification
The hardest cases are those where several rules would each take the same frame and only priority decides the class. Examples are an all-ones address that is offered with all-multicast and broadcast both enabled, or as a runt with broadcast enabled. A further hard case is a table entry that is present but masked off. The stimulus reaches these by first loading two entries and enabling only one of them. It then replays the same addresses under changing control settings, across the 59/60 length boundary, with trailing bytes after the address and with a frame that is cut short and restarted with a new start marker.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic accept;
    logic mcast;
    logic bcast;
  } rxf_verdict_t;

  localparam rxf_verdict_t VERDICT_NONE = '{accept: 1'b0, mcast: 1'b0, bcast: 1'b0};

  function automatic logic is_group(input logic [7:0] first_byte);
    return first_byte[0];
  endfunction

endpackage

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture #(
  parameter int ADDR_BYTES = 6,
  localparam int AW    = ADDR_BYTES * 8,
  localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] dest
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    dest_q, dest_d;
  logic             cap_en;

  assign cap_en = byte_vld && (sof || (cnt_q < CNT_W'(ADDR_BYTES)));

  always_comb begin
    cnt_d  = cnt_q;
    dest_d = dest_q;
    if (byte_vld && sof) begin
      dest_d[7:0] = byte_in;
      cnt_d       = CNT_W'(1);
    end else if (cap_en) begin
      dest_d[cnt_q*8 +: 8] = byte_in;
      cnt_d                = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(ADDR_BYTES);
      dest_q <= '0;
    end else if (cap_en) begin
      cnt_q  <= cnt_d;
      dest_q <= dest_d;
    end
  end

  assign dest = dest_q;

endmodule

// File: rtl/rxf_station_table.sv
module rxf_station_table #(
  parameter int N_ENTRIES  = 16,
  parameter int ADDR_BYTES = 6,
  localparam int AW     = ADDR_BYTES * 8,
  localparam int IDX_W  = $clog2(N_ENTRIES),
  localparam int WORDS  = ADDR_BYTES / 2,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [WORD_W-1:0]    wr_word,
  input  logic [15:0]          wr_data,
  input  logic                 mask_we,
  input  logic [N_ENTRIES-1:0] mask_data,
  input  logic [AW-1:0]        dest,
  output logic                 hit
);

  logic [N_ENTRIES-1:0] mask_q;
  logic [N_ENTRIES-1:0] match_vec;
  logic                 word_ok;

  assign word_ok = {1'b0, wr_word} < (WORD_W + 1)'(WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_data;
    end
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    logic [AW-1:0] ent_q, ent_d;
    logic          ent_we;

    assign ent_we = wr_en && word_ok && (wr_idx == IDX_W'(e));

    always_comb begin
      ent_d = ent_q;
      ent_d[wr_word*16 +: 16] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_we) begin
        ent_q <= ent_d;
      end
    end

    assign match_vec[e] = mask_q[e] && (ent_q == dest);
  end

  assign hit = |match_vec;

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 60,
  localparam int AW = ADDR_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof,
  input  logic [LEN_W-1:0] len,
  input  logic             runt_ok,
  input  logic             promisc,
  input  logic             all_mcast,
  input  logic             bcast_ok,
  input  logic [AW-1:0]    dest,
  input  logic             tbl_hit,
  output logic             done,
  output rxf_verdict_t     verdict
);

  rxf_verdict_t verdict_d, verdict_q;
  logic         done_q;
  logic         short_frame;
  logic         group_addr;
  logic         all_ones;

  assign short_frame = len < LEN_W'(MIN_LEN);
  assign group_addr  = is_group(dest[7:0]);
  assign all_ones    = &dest;

  always_comb begin
    verdict_d = VERDICT_NONE;
    if (short_frame) begin
      verdict_d.accept = runt_ok;
    end else if (promisc && !group_addr) begin
      verdict_d.accept = 1'b1;
    end else if (all_mcast && group_addr) begin
      verdict_d.accept = 1'b1;
      verdict_d.mcast  = 1'b1;
    end else if (bcast_ok && all_ones) begin
      verdict_d.accept = 1'b1;
      verdict_d.bcast  = 1'b1;
    end else if (tbl_hit) begin
      verdict_d.accept = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      verdict_q <= VERDICT_NONE;
    end else begin
      done_q <= eof;
      if (eof) begin
        verdict_q <= verdict_d;
      end
    end
  end

  assign done    = done_q;
  assign verdict = verdict_q;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int N_ENTRIES  = 16,
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 60,
  localparam int IDX_W  = $clog2(N_ENTRIES),
  localparam int WORDS  = ADDR_BYTES / 2,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_runt_ok,
  input  logic                 cfg_promisc,
  input  logic                 cfg_all_mcast,
  input  logic                 cfg_bcast_ok,
  input  logic                 tbl_wr_en,
  input  logic [IDX_W-1:0]     tbl_wr_idx,
  input  logic [WORD_W-1:0]    tbl_wr_word,
  input  logic [15:0]          tbl_wr_data,
  input  logic                 tbl_mask_we,
  input  logic [N_ENTRIES-1:0] tbl_mask_data,
  input  logic                 rx_sof,
  input  logic                 rx_byte_vld,
  input  logic [7:0]           rx_byte,
  input  logic                 rx_eof,
  input  logic [LEN_W-1:0]     rx_len,
  output logic                 flt_done,
  output logic                 flt_accept,
  output logic                 flt_mcast,
  output logic                 flt_bcast
);

  localparam int AW = ADDR_BYTES * 8;

  logic [AW-1:0] dest_q;
  logic          tbl_hit;
  rxf_verdict_t  verdict;

  rxf_dest_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof      (rx_sof),
    .byte_vld (rx_byte_vld),
    .byte_in  (rx_byte),
    .dest     (dest_q)
  );

  rxf_station_table #(.N_ENTRIES(N_ENTRIES), .ADDR_BYTES(ADDR_BYTES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_wr_en),
    .wr_idx    (tbl_wr_idx),
    .wr_word   (tbl_wr_word),
    .wr_data   (tbl_wr_data),
    .mask_we   (tbl_mask_we),
    .mask_data (tbl_mask_data),
    .dest      (dest_q),
    .hit       (tbl_hit)
  );

  rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .eof       (rx_eof),
    .len       (rx_len),
    .runt_ok   (cfg_runt_ok),
    .promisc   (cfg_promisc),
    .all_mcast (cfg_all_mcast),
    .bcast_ok  (cfg_bcast_ok),
    .dest      (dest_q),
    .tbl_hit   (tbl_hit),
    .done      (flt_done),
    .verdict   (verdict)
  );

  assign flt_accept = verdict.accept;
  assign flt_mcast  = verdict.mcast;
  assign flt_bcast  = verdict.bcast;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_eof,
  input logic [LEN_W-1:0] rx_len,
  input logic             cfg_runt_ok,
  input logic             cfg_promisc,
  input logic             cfg_all_mcast,
  input logic [7:0]       dest_first,
  input logic             flt_done,
  input logic             flt_accept,
  input logic             flt_mcast,
  input logic             flt_bcast
);

  logic is_short;
  assign is_short = rx_len < LEN_W'(MIN_LEN);

  assert_done_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eof |=> flt_done);

  assert_done_needs_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done |-> $past(rx_eof));

  assert_runt_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof && is_short && !cfg_runt_ok) |=> !flt_accept);

  assert_runt_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof && is_short && cfg_runt_ok) |=> (flt_accept && !flt_mcast && !flt_bcast));

  assert_promisc_unicast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof && !is_short && cfg_promisc && !dest_first[0])
      |=> (flt_accept && !flt_mcast && !flt_bcast));

  assert_all_mcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof && !is_short && cfg_all_mcast && dest_first[0])
      |=> (flt_accept && flt_mcast && !flt_bcast));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_mcast && flt_bcast));

  assert_flag_implies_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_mcast || flt_bcast) |-> flt_accept);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_done |-> ($stable(flt_accept) && $stable(flt_mcast) && $stable(flt_bcast)));

endmodule

bind rx_addr_filter rxf_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_rxf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_eof        (rx_eof),
  .rx_len        (rx_len),
  .cfg_runt_ok   (cfg_runt_ok),
  .cfg_promisc   (cfg_promisc),
  .cfg_all_mcast (cfg_all_mcast),
  .dest_first    (dest_q[7:0]),
  .flt_done      (flt_done),
  .flt_accept    (flt_accept),
  .flt_mcast     (flt_mcast),
  .flt_bcast     (flt_bcast)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/100ps
module test_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_runt_ok, cfg_promisc, cfg_all_mcast, cfg_bcast_ok;
  logic        tbl_wr_en;
  logic [3:0]  tbl_wr_idx;
  logic [1:0]  tbl_wr_word;
  logic [15:0] tbl_wr_data;
  logic        tbl_mask_we;
  logic [15:0] tbl_mask_data;
  logic        rx_sof, rx_byte_vld, rx_eof;
  logic [7:0]  rx_byte;
  logic [15:0] rx_len;
  logic        flt_done, flt_accept, flt_mcast, flt_bcast;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;
  string cur_tag  = "R1";

  always #2.5 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n),
    .cfg_runt_ok(cfg_runt_ok), .cfg_promisc(cfg_promisc),
    .cfg_all_mcast(cfg_all_mcast), .cfg_bcast_ok(cfg_bcast_ok),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_word(tbl_wr_word),
    .tbl_wr_data(tbl_wr_data), .tbl_mask_we(tbl_mask_we), .tbl_mask_data(tbl_mask_data),
    .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_eof(rx_eof), .rx_len(rx_len),
    .flt_done(flt_done), .flt_accept(flt_accept), .flt_mcast(flt_mcast), .flt_bcast(flt_bcast)
  );

  // Behavioural reference model
  int m_tbl [16][6];
  int m_mask;
  int m_dest [6];
  int m_cnt;
  bit m_done, m_acc, m_mc, m_bc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < 16; e++) for (int b = 0; b < 6; b++) m_tbl[e][b] = 0;
      for (int b = 0; b < 6; b++) m_dest[b] = 0;
      m_mask = 0; m_cnt = 6;
      m_done = 0; m_acc = 0; m_mc = 0; m_bc = 0;
    end else begin
      m_done = rx_eof;
      if (rx_eof) begin
        bit all_ff, hit;
        all_ff = 1; hit = 0;
        for (int b = 0; b < 6; b++) if (m_dest[b] != 255) all_ff = 0;
        for (int e = 0; e < 16; e++) begin
          bit same;
          same = 1;
          for (int b = 0; b < 6; b++) if (m_tbl[e][b] != m_dest[b]) same = 0;
          if (((m_mask >> e) & 1) == 1 && same) hit = 1;
        end
        m_acc = 0; m_mc = 0; m_bc = 0;
        if (rx_len < 60) m_acc = cfg_runt_ok;
        else if (cfg_promisc && (m_dest[0] % 2 == 0)) m_acc = 1;
        else if (cfg_all_mcast && (m_dest[0] % 2 == 1)) begin m_acc = 1; m_mc = 1; end
        else if (cfg_bcast_ok && all_ff) begin m_acc = 1; m_bc = 1; end
        else if (hit) m_acc = 1;
      end
      if (tbl_wr_en && tbl_wr_word < 3) begin
        m_tbl[tbl_wr_idx][2*tbl_wr_word]     = int'(tbl_wr_data[7:0]);
        m_tbl[tbl_wr_idx][2*tbl_wr_word + 1] = int'(tbl_wr_data[15:8]);
      end
      if (tbl_mask_we) m_mask = int'(tbl_mask_data);
      if (rx_byte_vld) begin
        if (rx_sof) begin m_dest[0] = int'(rx_byte); m_cnt = 1; end
        else if (m_cnt < 6) begin m_dest[m_cnt] = int'(rx_byte); m_cnt++; end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Compare against the model on every clock (R2, R10 and current scenario)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cur_tag, "model done",   int'(flt_done),   int'(m_done));
      chk(cur_tag, "model accept", int'(flt_accept), int'(m_acc));
      chk(cur_tag, "model mcast",  int'(flt_mcast),  int'(m_mc));
      chk(cur_tag, "model bcast",  int'(flt_bcast),  int'(m_bc));
    end
  end

  task automatic tbl_write(input int idx, input int word, input logic [15:0] data);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_idx = 4'(idx); tbl_wr_word = 2'(word); tbl_wr_data = data;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic mask_write(input logic [15:0] m);
    @(negedge clk);
    tbl_mask_we = 1; tbl_mask_data = m;
    @(negedge clk);
    tbl_mask_we = 0;
  endtask

  task automatic set_cfg(input bit runt, input bit pro, input bit amc, input bit bc);
    @(negedge clk);
    cfg_runt_ok = runt; cfg_promisc = pro; cfg_all_mcast = amc; cfg_bcast_ok = bc;
  endtask

  task automatic send_frame(input logic [47:0] d, input int extra, input int len,
                            input string tag, input bit e_acc, input bit e_mc, input bit e_bc);
    cur_tag = tag;
    for (int i = 0; i < 6 + extra; i++) begin
      @(negedge clk);
      rx_sof = (i == 0); rx_byte_vld = 1;
      rx_byte = (i < 6) ? d[8*i +: 8] : 8'(8'h5A ^ i);
    end
    @(negedge clk);
    rx_sof = 0; rx_byte_vld = 0; rx_eof = 1; rx_len = 16'(len);
    @(negedge clk);
    rx_eof = 0;
    chk(tag, "done pulse", int'(flt_done), 1);
    chk(tag, "accept", int'(flt_accept), int'(e_acc));
    chk(tag, "mcast",  int'(flt_mcast),  int'(e_mc));
    chk(tag, "bcast",  int'(flt_bcast),  int'(e_bc));
    @(negedge clk);
    chk("R2", "done single cycle", int'(flt_done), 0);
    chk("R10", "accept held", int'(flt_accept), int'(e_acc));
  endtask

  localparam logic [47:0] ADDR_E3   = 48'h554433221102;
  localparam logic [47:0] ADDR_E9   = 48'hEEDDCCBBAA02;
  localparam logic [47:0] ADDR_NEAR = 48'h564433221102;
  localparam logic [47:0] ADDR_UNI  = 48'h000000000004;
  localparam logic [47:0] ADDR_MC   = 48'h0100005E0001;
  localparam logic [47:0] ADDR_BC   = 48'hFFFFFFFFFFFF;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cfg_runt_ok = 0; cfg_promisc = 0; cfg_all_mcast = 0; cfg_bcast_ok = 0;
    tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_word = 0; tbl_wr_data = 0;
    tbl_mask_we = 0; tbl_mask_data = 0;
    rx_sof = 0; rx_byte_vld = 0; rx_byte = 0; rx_eof = 0; rx_len = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset done",   int'(flt_done), 0);
    chk("R1", "reset accept", int'(flt_accept), 0);
    chk("R1", "reset mcast",  int'(flt_mcast), 0);
    chk("R1", "reset bcast",  int'(flt_bcast), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: fresh table is disabled, even an all-zero address is not taken
    send_frame(48'h0, 0, 64, "R1", 0, 0, 0);

    // R8: load entries, word 3 must be ignored
    tbl_write(3, 0, 16'h1102);
    tbl_write(3, 1, 16'h3322);
    tbl_write(3, 2, 16'h5544);
    tbl_write(3, 3, 16'hDEAD);
    tbl_write(9, 0, 16'hAA02);
    tbl_write(9, 1, 16'hCCBB);
    tbl_write(9, 2, 16'hEEDD);
    mask_write(16'h0008);

    send_frame(ADDR_E3,   0, 64, "R8", 1, 0, 0);
    send_frame(ADDR_E9,   0, 64, "R7", 0, 0, 0);
    send_frame(ADDR_NEAR, 0, 64, "R9", 0, 0, 0);

    // R3: short frames and the 59/60 edge
    send_frame(ADDR_E3, 0, 59, "R3", 0, 0, 0);
    send_frame(ADDR_E3, 0, 60, "R3", 1, 0, 0);
    set_cfg(1, 0, 0, 1);
    send_frame(ADDR_BC, 0, 59, "R3", 1, 0, 0);
    send_frame(ADDR_NEAR, 0, 20, "R3", 1, 0, 0);

    // R4: promiscuous
    set_cfg(0, 1, 0, 0);
    send_frame(ADDR_UNI, 0, 64, "R4", 1, 0, 0);
    send_frame(ADDR_MC,  0, 64, "R4", 0, 0, 0);

    // R5: all-multicast, takes precedence over broadcast
    set_cfg(0, 0, 1, 0);
    send_frame(ADDR_MC, 0, 64, "R5", 1, 1, 0);
    set_cfg(0, 0, 1, 1);
    send_frame(ADDR_BC, 0, 64, "R5", 1, 1, 0);
    send_frame(ADDR_UNI, 0, 64, "R9", 0, 0, 0);

    // R6: broadcast
    set_cfg(0, 0, 0, 1);
    send_frame(ADDR_BC, 0, 64, "R6", 1, 0, 1);
    send_frame(ADDR_MC, 0, 64, "R6", 0, 0, 0);
    set_cfg(0, 0, 0, 0);
    send_frame(ADDR_BC, 0, 64, "R6", 0, 0, 0);

    // R7: enabling entry 9 makes it match
    mask_write(16'h0208);
    send_frame(ADDR_E9, 0, 64, "R7", 1, 0, 0);
    mask_write(16'h0200);
    send_frame(ADDR_E3, 0, 64, "R7", 0, 0, 0);
    mask_write(16'h0008);

    // R11: trailing bytes ignored; restart on new start marker
    send_frame(ADDR_E3, 12, 1500, "R11", 1, 0, 0);
    cur_tag = "R11";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_sof = (i == 0); rx_byte_vld = 1; rx_byte = 8'hFF;
    end
    send_frame(ADDR_E3, 0, 64, "R11", 1, 0, 0);

    // R10: verdict held over idle cycles
    cur_tag = "R10";
    repeat (5) @(negedge clk);
    chk("R10", "accept after idle", int'(flt_accept), 1);
    chk("R10", "mcast after idle",  int'(flt_mcast), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule